// File: doc/BRIEF.md
# Prefetching Free-Cell Allocator Front End

This unit keeps a single spare memory cell address ready for a consumer state machine. The consumer can then start building linked nodes without waiting on a round trip to the memory manager. Whenever the unit holds no address and has no request in flight, it raises an allocate command on a valid/ready command channel. It captures the cell address that comes back on the response channel and presents it to the consumer together with a valid flag.

When the consumer takes the address, the unit drops its slot. In that same cycle it presents the next allocate command. No request from the consumer is involved. A take strobe given while no address is held has no effect. At any moment the unit is in one of three conditions: holding an address, waiting for one response, or idle and requesting. For this reason a take and an accepted response can never fall in the same cycle, and no address can be lost.

Top module: `cell_prefetch`

## Requirements
- R1: While reset is asserted, `cmd_valid` and `addr_valid` are 0. In the first cycle after reset is released, `cmd_valid` is 1 and `addr_valid` is 0.
- R2: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid` stays 1 in the next cycle. Whenever `cmd_valid` is 1, `cmd_op` carries the parameter `OP_PICKUP` (default 4'h1).
- R3: At most one allocate request is outstanding. After a command handshake, `cmd_valid` stays 0 until the response has been accepted and its address has been taken. `rsp_ready` and `addr_valid` are never 1 together.
- R4: `rsp_ready` is 1 exactly while a request is outstanding. The cycle after a response handshake, `addr_valid` is 1 and `addr` equals the `rsp_addr` of that handshake.
- R5: While `addr_valid` is 1 and `take` is 0, `addr_valid` stays 1 and `addr` stays unchanged in the next cycle.
- R6: When `take` is 1 while `addr_valid` is 1, `cmd_valid` is 1 in that same cycle and `addr_valid` is 0 in the next cycle.
- R7: `take` while `addr_valid` is 0 is ignored. It raises no extra command, and the next address delivered is still the next response's address.
- R8: The addresses handed to the consumer are exactly the response addresses in arrival order, with none dropped or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | output | 1 | Allocate command valid |
| cmd_ready | input | 1 | Manager accepts the command |
| cmd_op | output | OP_W | Command opcode (allocate) |
| rsp_valid | input | 1 | Manager response valid |
| rsp_ready | output | 1 | Unit accepts the response |
| rsp_addr | input | ADDR_W | Allocated cell address |
| addr_valid | output | 1 | Held address is available |
| addr | output | ADDR_W | Held cell address |
| take | input | 1 | Consumer takes the held address |

## Verification
The first directed pattern strobes `take` while the manager refuses commands and no address is held. This separates a correctly ignored take from one that corrupts the slot or issues extra requests. The second directed pattern holds the address untaken while the manager is always ready. This exposes any second outstanding request and any drift of the held address. A random mix of manager readiness, response latencies of zero to five cycles and consumer takes then tests the back-to-back path. In that path a take is immediately followed by a new command and by a response that may land on the very next cycle. This separates correct same-cycle refill from off-by-one-cycle or lost-address behaviour.

// File: rtl/cell_prefetch.sv
module cell_prefetch #(
  parameter int              ADDR_W    = 32,
  parameter int              OP_W      = 4,
  parameter logic [OP_W-1:0] OP_PICKUP = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [OP_W-1:0]   cmd_op,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [ADDR_W-1:0] rsp_addr,
  output logic              addr_valid,
  output logic [ADDR_W-1:0] addr,
  input  logic              take
);

  logic              full;
  logic              pending;
  logic [ADDR_W-1:0] held;

  assign cmd_valid  = rst_n & ~pending & (~full | take);
  assign cmd_op     = OP_PICKUP;
  assign rsp_ready  = pending;
  assign addr_valid = full;
  assign addr       = held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      pending <= 1'b0;
      held    <= '0;
    end else begin
      if (cmd_valid && cmd_ready)
        pending <= 1'b1;
      else if (rsp_valid && pending)
        pending <= 1'b0;

      if (rsp_valid && pending) begin
        full <= 1'b1;
        held <= rsp_addr;
      end else if (take && full) begin
        full <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cell_prefetch_chk.sv
module cell_prefetch_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              addr_valid,
  input logic [ADDR_W-1:0] addr,
  input logic              take
);

  assert_cmd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid);

  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_valid);

  assert_ready_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !addr_valid);

  assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> addr_valid && addr == $past(rsp_addr));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && !take |=> addr_valid && $stable(addr));

  assert_refill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && take |-> cmd_valid);

  assert_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && take |=> !addr_valid);

endmodule

bind cell_prefetch cell_prefetch_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
  .addr_valid(addr_valid), .addr(addr), .take(take)
);

// File: tb/test_cell_prefetch.sv
`timescale 1ns/1ps
module test_cell_prefetch;
  localparam int ADDR_W = 32;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP = 4'h1;
  localparam int CYCLES = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid, cmd_ready = 1'b0;
  logic [OP_W-1:0] cmd_op;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [ADDR_W-1:0] rsp_addr = '0;
  logic addr_valid;
  logic [ADDR_W-1:0] addr;
  logic take = 1'b0;

  always #2.5 clk = ~clk;

  cell_prefetch #(.ADDR_W(ADDR_W), .OP_W(OP_W), .OP_PICKUP(OP)) i_cell_prefetch (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_addr(rsp_addr), .addr_valid(addr_valid), .addr(addr), .take(take)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic bit exp_cmd(input bit pend, input bit full, input bit tk);
    return !pend && (!full || tk);
  endfunction

  function automatic logic [ADDR_W-1:0] next_cell(input logic [ADDR_W-1:0] a, input int unsigned r);
    return a + 32'h10 + {24'd0, 4'(r % 8), 4'h0};
  endfunction

  bit mfull = 0, mpend = 0, mgr_busy = 0;
  int mgr_lat = 0;
  logic [ADDR_W-1:0] maddr = '0;
  logic [ADDR_W-1:0] next_addr = 32'h1000;
  int resp_cnt = 0, take_cnt = 0;

  initial begin
    #(200000 * 5.0);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(cmd_valid == 1'b0, "R1 cmd_valid in reset", 64'(cmd_valid), 64'd0);
      chk(addr_valid == 1'b0, "R1 addr_valid in reset", 64'(addr_valid), 64'd0);
    end
    rst_n = 1'b1;
    #1;
    chk(cmd_valid == 1'b1, "R1 first request after reset", 64'(cmd_valid), 64'd1);

    for (int i = 0; i < CYCLES; i++) begin
      bit cf, rf, tf;
      if (i != 0) @(negedge clk);
      chk(addr_valid == mfull, "R4/R5 addr_valid", 64'(addr_valid), 64'(mfull));
      if (mfull) chk(addr == maddr, "R5/R8 held addr", 64'(addr), 64'(maddr));
      chk(rsp_ready == mpend, "R4 rsp_ready", 64'(rsp_ready), 64'(mpend));
      chk(!(rsp_ready && addr_valid), "R3 ready with addr", 64'(rsp_ready), 64'd0);

      rsp_valid = mgr_busy && (mgr_lat == 0);
      rsp_addr  = rsp_valid ? next_addr : '0;
      if (i < 8) begin
        cmd_ready = 1'b0; take = 1'b1;
      end else if (i < 40) begin
        cmd_ready = 1'b1; take = 1'b0;
      end else begin
        cmd_ready = ($urandom % 4) != 0;
        take = ($urandom % 3) == 0;
      end
      #1;
      chk(cmd_valid == exp_cmd(mpend, mfull, take), "R2/R3/R6/R7 cmd_valid",
          64'(cmd_valid), 64'(exp_cmd(mpend, mfull, take)));
      if (cmd_valid) chk(cmd_op == OP, "R2 cmd_op", 64'(cmd_op), 64'(OP));

      cf = cmd_valid && cmd_ready;
      rf = rsp_valid && rsp_ready;
      tf = take && addr_valid;
      if (tf) begin
        chk(addr == maddr, "R8 taken addr order", 64'(addr), 64'(maddr));
        take_cnt++;
      end
      if (cf) begin
        chk(!mgr_busy, "R3 second outstanding request", 64'(mgr_busy), 64'd0);
        mgr_busy = 1; mpend = 1;
        mgr_lat = $urandom % 6;
      end else if (mgr_busy && mgr_lat > 0) begin
        mgr_lat--;
      end
      if (rf) begin
        mgr_busy = 0; mpend = 0; mfull = 1;
        maddr = rsp_addr;
        next_addr = next_cell(next_addr, $urandom);
        resp_cnt++;
      end else if (tf) begin
        mfull = 0;
      end
    end

    @(negedge clk);
    chk(resp_cnt - take_cnt == int'(mfull), "R8 no address lost",
        64'(resp_cnt - take_cnt), 64'(mfull));
    chk(take_cnt > 100, "R6 refill throughput", 64'(take_cnt), 64'd100);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule